// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This block holds the interrupt bookkeeping for a UART: a three-bit enable register and an event register. A receiver and a transmitter placed beside it report their activity through one-cycle event pulses and one level signal. The block keeps parity, framing and overrun errors as sticky bits. It does the same for "receive buffer loaded" and "transmit buffer handed to the shifter". It tracks whether a receive frame is in progress, shows the transmitter's busy level, and drives one level interrupt request to an interrupt controller.

Software reaches the block over a byte-wide register bus with combinational reads. Sticky bits are cleared by writing 1 to them. The block only responds while the UART mode input is high. In any other mode it ignores writes and events, keeps the interrupt low and reads back zero.

Top module: `uart_irq_status`

## Requirements
- R1: After a synchronous active-low reset, both registers read 0x00 and `irq` is low.
- R2: A write at offset 1 loads data bits 2..0 into the enable register: bit 2 is the receive-error enable, bit 1 the receive-full enable, bit 0 the transmit-empty enable. A read at offset 1 returns these three bits, with bits 7..3 read as 0.
- R3: At offset 2, bit 4 is set by `ev_parity_err`, bit 3 by `ev_frame_err`, bit 2 by `ev_overrun`, bit 1 by `ev_rx_load` and bit 0 by `ev_tx_load`. Each bit reads 1 from the cycle after its pulse and stays 1 until software clears it.
- R4: A write at offset 2 clears each of bits 4..0 whose data bit is 1 and leaves the others unchanged. Write data in bits 7..5 has no effect, and bit 7 always reads 0.
- R5: When an event and a write-1 clear reach the same bit in the same cycle, the bit ends up set.
- R6: Bit 6 at offset 2 (receive busy) becomes 1 in the cycle after `ev_rx_start` and returns to 0 in the cycle after `ev_rx_load`, unless `ev_rx_start` is also high in that cycle.
- R7: Bit 5 at offset 2 (transmit busy) shows the `tx_active` input in the same cycle.
- R8: `irq` is high exactly when one of the following holds: enable bit 2 is set and any of the three error bits is set, enable bit 1 is set and the receive-full bit is set, or enable bit 0 is set and the transmit-empty bit is set.
- R9: While `uart_mode` is low, writes and events change no state, `irq` is low and reads return 0x00.
- R10: Writes at offsets other than 1 and 2 change nothing, and reads there return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| uart_mode | input | 1 | High while the serial unit is in UART mode |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the offset |
| ev_rx_start | input | 1 | Pulse: start bit detected |
| ev_rx_load | input | 1 | Pulse: received byte loaded into the receive buffer |
| ev_tx_load | input | 1 | Pulse: transmit buffer moved into the shift register |
| ev_parity_err | input | 1 | Pulse: parity error on the received byte |
| ev_frame_err | input | 1 | Pulse: stop bit missing |
| ev_overrun | input | 1 | Pulse: receive buffer overwritten before it was read |
| tx_active | input | 1 | Level: transmitter shifting |
| irq | output | 1 | Level interrupt request |

## Verification
On every cycle, the assertions check per-bit sticky behaviour: an event forces its bit high, a set bit holds unless cleared, and a clear without an event drops the bit. They also check that the receive-busy tracker follows start and load pulses, and that enable and event state stay frozen outside UART mode. The bench alone can show the full read image at each offset, the interrupt equation across all enable and flag combinations, the unused-offset behaviour, and the directed collision of a clear with an event.

// File: rtl/uart_irq_pkg.sv
// Shared constants for the UART interrupt status unit.
// Assumes a byte-wide register bus with a small offset field.
package uart_irq_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 2;
    localparam int N_EN      = 3;
    localparam int N_STICKY  = 5;
    localparam logic [ADDR_W-1:0] OFS_ENABLE = 2'd1;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 2'd2;
    // enable bit positions
    localparam int EN_RXERR  = 2;
    localparam int EN_RXFULL = 1;
    localparam int EN_TXEMPT = 0;
    // event register bit positions
    localparam int BIT_RXBSY = 6;
    localparam int BIT_TXBSY = 5;
    localparam int BIT_PAR   = 4;
    localparam int BIT_FRM   = 3;
    localparam int BIT_OVR   = 2;
    localparam int BIT_RXFUL = 1;
    localparam int BIT_TXEMP = 0;
endpackage

// File: rtl/irq_enable_reg.sv
// Interrupt enable register. Loads the low N_EN data bits on a qualified
// write strobe. Assumes the caller already gated the strobe with mode and address.
module irq_enable_reg #(
    parameter int DATA_W = 8,
    parameter int N_EN   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [N_EN-1:0]   en_q
);
    // capture enable bits on a qualified write
    always_ff @(posedge clk) begin
        if (!rst_n)     en_q <= '0;
        else if (wr_en) en_q <= wdata[N_EN-1:0];
    end

    // R9
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(en_q));
endmodule

// File: rtl/irq_sticky_flags.sv
// Bank of sticky event bits. A set pulse forces a bit high. A clear pulse
// drops it unless a set arrives in the same cycle. Assumes set and clear are pre-gated.
module irq_sticky_flags #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flag_q
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // one sticky bit, set has priority over clear
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (set_vec[i]) flag_q[i] <= 1'b1;
            else if (clr_vec[i]) flag_q[i] <= 1'b0;
        end

        // R5
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[i] |=> flag_q[i]);
        // R3
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[i] && !clr_vec[i]) |=> flag_q[i]);
        // R4
        clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vec[i] && !set_vec[i]) |=> !flag_q[i]);
    end
endmodule

// File: rtl/rx_busy_tracker.sv
// Receive busy tracker: high from a start-bit pulse until the byte is
// loaded into the receive buffer. A start in the same cycle as a load wins.
module rx_busy_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic start_pulse,
    input  logic load_pulse,
    output logic busy_q
);
    // follow the receive framing while active
    always_ff @(posedge clk) begin
        if (!rst_n)                    busy_q <= 1'b0;
        else if (active && start_pulse) busy_q <= 1'b1;
        else if (active && load_pulse)  busy_q <= 1'b0;
    end

    // R6
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && start_pulse) |=> busy_q);
    // R6
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && load_pulse && !start_pulse) |=> !busy_q);
endmodule

// File: rtl/irq_combine.sv
// Interrupt request combiner: ORs each enabled event term. Any of the
// three error bits feeds the single receive-error enable.
module irq_combine #(
    parameter int N_EN     = 3,
    parameter int N_STICKY = 5
) (
    input  logic [N_EN-1:0]     en,
    input  logic [N_STICKY-1:0] flags,
    output logic                req
);
    import uart_irq_pkg::*;
    logic err_any;

    // merge error bits, then gate each term with its enable
    always_comb begin
        err_any = flags[BIT_PAR] | flags[BIT_FRM] | flags[BIT_OVR];
        req = (en[EN_RXERR]  & err_any)
            | (en[EN_RXFULL] & flags[BIT_RXFUL])
            | (en[EN_TXEMPT] & flags[BIT_TXEMP]);
    end
endmodule

// File: rtl/uart_irq_status.sv
// UART interrupt status and enable unit. It decodes the register bus,
// gates all activity with the UART mode input, and builds the read image and
// the level interrupt request. Assumes event inputs are one-cycle pulses
// synchronous to clk.
module uart_irq_status
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              uart_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ev_rx_start,
    input  logic              ev_rx_load,
    input  logic              ev_tx_load,
    input  logic              ev_parity_err,
    input  logic              ev_frame_err,
    input  logic              ev_overrun,
    input  logic              tx_active,
    output logic              irq
);
    logic                wr_enable, wr_event;
    logic [N_EN-1:0]     en_q;
    logic [N_STICKY-1:0] set_vec, clr_vec, flag_q;
    logic                rx_busy;
    logic                req;

    // decode qualified writes and gated event pulses
    always_comb begin
        wr_enable = uart_mode && bus_wr && (bus_addr == OFS_ENABLE);
        wr_event  = uart_mode && bus_wr && (bus_addr == OFS_EVENT);
        set_vec   = '0;
        if (uart_mode) begin
            set_vec[BIT_PAR]   = ev_parity_err;
            set_vec[BIT_FRM]   = ev_frame_err;
            set_vec[BIT_OVR]   = ev_overrun;
            set_vec[BIT_RXFUL] = ev_rx_load;
            set_vec[BIT_TXEMP] = ev_tx_load;
        end
        clr_vec = wr_event ? bus_wdata[N_STICKY-1:0] : '0;
    end

    irq_enable_reg #(.DATA_W(DATA_W), .N_EN(N_EN)) u_en (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_enable), .wdata(bus_wdata), .en_q(en_q));

    irq_sticky_flags #(.N(N_STICKY)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flag_q(flag_q));

    rx_busy_tracker u_rxb (
        .clk(clk), .rst_n(rst_n), .active(uart_mode), .start_pulse(ev_rx_start),
        .load_pulse(ev_rx_load), .busy_q(rx_busy));

    irq_combine #(.N_EN(N_EN), .N_STICKY(N_STICKY)) u_irq (
        .en(en_q), .flags(flag_q), .req(req));

    // build the read image for the addressed register
    always_comb begin
        bus_rdata = '0;
        if (uart_mode) begin
            if (bus_addr == OFS_ENABLE) begin
                bus_rdata[N_EN-1:0] = en_q;
            end else if (bus_addr == OFS_EVENT) begin
                bus_rdata[N_STICKY-1:0] = flag_q;
                bus_rdata[BIT_TXBSY]    = tx_active;
                bus_rdata[BIT_RXBSY]    = rx_busy;
            end
        end
    end

    // gate the request with the mode
    always_comb irq = uart_mode & req;

    // R9
    mode_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !uart_mode |=> $stable(flag_q));
    // R8
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flag_q != '0));
endmodule

// File: tb/tb_uart_irq_status.sv
// Self-checking bench: a reference model computed by bench functions,
// directed corner cases followed by seeded random stimulus.
module tb_uart_irq_status;
    logic       clk = 1'b0;
    logic       rst_n, uart_mode, bus_wr;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata, bus_rdata;
    logic       ev_rx_start, ev_rx_load, ev_tx_load;
    logic       ev_parity_err, ev_frame_err, ev_overrun, tx_active, irq;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    // model state
    logic [2:0] m_en;
    logic [4:0] m_fl;
    logic       m_rxb;

    always #4 clk = ~clk;

    uart_irq_status dut (
        .clk(clk), .rst_n(rst_n), .uart_mode(uart_mode), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_rx_start(ev_rx_start), .ev_rx_load(ev_rx_load), .ev_tx_load(ev_tx_load),
        .ev_parity_err(ev_parity_err), .ev_frame_err(ev_frame_err),
        .ev_overrun(ev_overrun), .tx_active(tx_active), .irq(irq));

    function automatic logic [7:0] exp_read(input logic m, input logic [1:0] a, input logic ta);
        if (!m)        return 8'h00;
        if (a == 2'd1) return {5'b0, m_en};
        if (a == 2'd2) return {1'b0, m_rxb, ta, m_fl};
        return 8'h00;
    endfunction

    function automatic logic exp_irq(input logic m);
        return m & ((m_en[2] & |m_fl[4:2]) | (m_en[1] & m_fl[1]) | (m_en[0] & m_fl[0]));
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // ev = {parity, frame, overrun, rx_load, tx_load}
    task automatic step(input string tag, input logic m, input logic [1:0] a,
                        input logic w, input logic [7:0] d, input logic [4:0] ev,
                        input logic st, input logic ta);
        @(negedge clk);
        uart_mode = m; bus_addr = a; bus_wr = w; bus_wdata = d;
        {ev_parity_err, ev_frame_err, ev_overrun, ev_rx_load, ev_tx_load} = ev;
        ev_rx_start = st; tx_active = ta;
        #3;
        check(tag, bus_rdata, exp_read(m, a, ta));
        check({tag, " irq"}, {7'b0, irq}, {7'b0, exp_irq(m)});
        @(posedge clk);
        if (m) begin
            if (w && a == 2'd1) m_en = d[2:0];
            m_fl = (m_fl & ~((w && a == 2'd2) ? d[4:0] : 5'b0)) | ev;
            if (st) m_rxb = 1'b1;
            else if (ev[1]) m_rxb = 1'b0;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        rst_n = 1'b0; uart_mode = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
        {ev_parity_err, ev_frame_err, ev_overrun, ev_rx_load, ev_tx_load, ev_rx_start} = '0;
        tx_active = 1'b0;
        m_en = '0; m_fl = '0; m_rxb = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        step("R1", 1, 2'd1, 0, 8'h00, 5'h00, 0, 0);
        step("R1", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        // R2 enable write, upper bits ignored
        step("R2", 1, 2'd1, 1, 8'hFA, 5'h00, 0, 0);
        step("R2", 1, 2'd1, 0, 8'h00, 5'h00, 0, 0);
        step("R2", 1, 2'd1, 1, 8'h00, 5'h00, 0, 0);
        // R3 parity event sticks, no enable so no irq
        step("R3", 1, 2'd2, 0, 8'h00, 5'h10, 0, 0);
        step("R3", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        step("R3", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        // R8 error enable raises irq from parity bit
        step("R8", 1, 2'd1, 1, 8'h04, 5'h00, 0, 0);
        step("R8", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        // R4 write 0 keeps, upper write bits harmless, write 1 clears
        step("R4", 1, 2'd2, 1, 8'hE0, 5'h00, 0, 0);
        step("R4", 1, 2'd2, 1, 8'h10, 5'h00, 0, 0);
        step("R4", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        // R5 set beats clear
        step("R5", 1, 2'd2, 1, 8'h1F, 5'h1F, 0, 0);
        step("R5", 1, 2'd2, 1, 8'h1F, 5'h00, 0, 0);
        step("R5", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        // R6 receive busy framing
        step("R6", 1, 2'd2, 0, 8'h00, 5'h00, 1, 0);
        step("R6", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        step("R6", 1, 2'd2, 0, 8'h00, 5'h02, 0, 0);
        step("R6", 1, 2'd2, 1, 8'h1F, 5'h00, 0, 0);
        // R7 transmit busy mirrors input
        step("R7", 1, 2'd2, 0, 8'h00, 5'h00, 0, 1);
        step("R7", 1, 2'd2, 0, 8'h00, 5'h01, 0, 0);
        // R9 outside UART mode: nothing changes, reads 0, irq low
        step("R8", 1, 2'd1, 1, 8'h07, 5'h00, 0, 0);
        step("R9", 0, 2'd1, 1, 8'h00, 5'h1F, 1, 1);
        step("R9", 0, 2'd2, 1, 8'hFF, 5'h00, 0, 0);
        step("R9", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        step("R9", 1, 2'd1, 0, 8'h00, 5'h00, 0, 0);
        // R10 unused offsets
        step("R10", 1, 2'd3, 1, 8'hFF, 5'h00, 0, 0);
        step("R10", 1, 2'd0, 1, 8'hFF, 5'h00, 0, 0);
        step("R10", 1, 2'd2, 0, 8'h00, 5'h00, 0, 0);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            logic [1:0] a;
            logic [4:0] ev;
            logic m;
            string tg;
            a  = 2'($urandom_range(0, 3));
            m  = ($urandom_range(0, 9) != 0);
            ev = 5'($urandom) & 5'($urandom);
            if (!m)          tg = "R9";
            else if (a == 1) tg = "R2";
            else if (a == 2) tg = "R3";
            else             tg = "R10";
            step(tg, m, a, ($urandom_range(0, 3) == 0), 8'($urandom), ev,
                 ($urandom_range(0, 7) == 0), 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule